// File: doc/BRIEF.md
# DMA Write-Cycle Wait-State Controller

This block times single-mode DMA memory write cycles on an external bus. When a cycle begins, it looks at three things: the 3-bit target area, the kind of space being written (normal memory, DRAM column access, or multiplexed address/data I/O) and a per-area control bit. From these it chooses a fixed number of bus states. It also decides whether the active-low WAIT input may stretch the cycle.

Areas 0, 2 and 6 also take programmable long-wait states from a 16-bit long-wait register. That register also carries a pull-up enable for the WAIT pad, which the block drives out as a plain control pin.

The bus master pulses `start` with the area and space. `busy` stays high for every state of the cycle. `done` marks the final state. Both registers are reset only by power-on reset. A manual reset aborts the cycle in progress and leaves the register contents unchanged.

Top module: `dma_wr_wait_ctl`

## Requirements
- R1: In normal space (`space`=0 or 3), when the area's control bit is 0, a write to area 1, 3, 4, 5 or 7 lasts exactly 1 state and `wait_n` has no effect.
- R2: In normal space, when the area's control bit is 1, a write to area 1, 3, 4, 5 or 7 lasts 2 states plus 1 state for every sample that finds `wait_n` low.
- R3: In normal space, a write to area 0, 2 or 6 lasts 1 state plus code+1 long-wait states, where code is the 2-bit field for that area. WAIT extends it only when the area's control bit is 1.
- R4: In DRAM column space (`space`=1), the cycle lasts 1 state with WAIT ignored when the area's control bit is 0. When the bit is 1, it lasts 2 states plus WAIT extension. Long-wait codes have no effect in this space.
- R5: In multiplexed I/O space (`space`=2), the cycle lasts 4 states plus WAIT extension, whatever the control bit says.
- R6: Long-wait register (`reg_sel`=1): bit 15 drives `wait_pu_en`, bits 14:13 are the code for areas 0 and 2, and bits 12:11 are the code for area 6. Bits 10:0 read as 0 and ignore writes. The power-on value is 0xF800.
- R7: Control register (`reg_sel`=0): bit i is the control bit for area i, and bits 15:8 read as 0. All bits are 1 after power-on reset.
- R8: Taking `mrst_n` low ends any cycle at once (`busy` and `done` go low) and leaves both registers unchanged. Taking `por_n` low restores the power-on register values.
- R9: `busy` is high for exactly the states of the cycle, starting the clock after the accepted `start`. `done` is high for one clock only, in the last busy state. A `start` while `busy` is high is ignored.
- R10: WAIT is sampled at the edge that ends the last fixed state and each added state. A low sample adds one state. A high sample ends the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, asynchronous; cycle logic only |
| start | input | 1 | Begin a write cycle; accepted only when idle |
| area | input | 3 | Target area number, sampled with start |
| space | input | 2 | 0 normal, 1 DRAM column, 2 multiplexed I/O, 3 as normal |
| wait_n | input | 1 | External WAIT, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 control register, 1 long-wait register |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_sel |
| wait_pu_en | output | 1 | WAIT pad pull-up enable (long-wait bit 15) |
| busy | output | 1 | High during every state of a cycle |
| done | output | 1 | One-clock pulse in the final state |

## Verification
`busy` rises one clock after the edge that accepts `start`, so the bench counts busy states from the first falling edge after that. `done` depends on the WAIT value of the state it marks. The bench therefore sets `wait_n` at each falling edge and samples `done` a short delay later, before the closing rising edge. Register writes take effect at the next rising edge and read back combinationally, so each read is checked at the following falling edge. Manual reset is asynchronous, so `busy` is checked a short delay after `mrst_n` falls.

// File: rtl/dma_ww_pkg.sv
package dma_ww_pkg;
  typedef enum logic [1:0] {
    SP_NORM = 2'd0,
    SP_DRAM = 2'd1,
    SP_MUX  = 2'd2,
    SP_RSV  = 2'd3
  } space_e;

  localparam int unsigned REG_W     = 16;
  localparam int unsigned CODE_W    = 2;
  localparam int unsigned PU_BIT    = 15;
  localparam int unsigned LW02_LSB  = 13;
  localparam int unsigned LW6_LSB   = 11;
  localparam logic [15:0] LW_RESET  = 16'hF800;
endpackage

// File: rtl/dma_ww_regs.sv
module dma_ww_regs
  import dma_ww_pkg::*;
#(
  parameter int unsigned NAREA = 8
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    wr,
  input  logic                    sel,
  input  logic [REG_W-1:0]        wdata,
  output logic [REG_W-1:0]        rdata,
  output logic [NAREA-1:0]        ctl_bits,
  output logic [CODE_W-1:0]       lw02_code,
  output logic [CODE_W-1:0]       lw6_code,
  output logic                    pu_en
);
  localparam int unsigned LW_KEEP = REG_W - LW6_LSB;

  logic [LW_KEEP-1:0] lw_q;

  genvar gi;
  generate
    for (gi = 0; gi < NAREA; gi++) begin : g_ctl
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              ctl_bits[gi] <= 1'b1;
        else if (wr && !sel)     ctl_bits[gi] <= wdata[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          lw_q <= LW_RESET[REG_W-1:LW6_LSB];
    else if (wr && sel)  lw_q <= wdata[REG_W-1:LW6_LSB];
  end

  assign pu_en     = lw_q[PU_BIT-LW6_LSB];
  assign lw02_code = lw_q[LW02_LSB-LW6_LSB +: CODE_W];
  assign lw6_code  = lw_q[0 +: CODE_W];

  always_comb begin
    rdata = '0;
    if (sel) rdata[REG_W-1:LW6_LSB] = lw_q;
    else     rdata[NAREA-1:0]       = ctl_bits;
  end

  // R6: reserved long-wait bits always read zero
  p_rsv_zero_r6: assert property (@(posedge clk) disable iff (!por_n)
    sel |-> (rdata[LW6_LSB-1:0] == '0));

  // R8: without a write the register contents hold (manual reset has no path here)
  p_regs_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    !wr |=> ($stable(ctl_bits) && $stable(lw_q)));
endmodule

// File: rtl/dma_ww_len.sv
module dma_ww_len
  import dma_ww_pkg::*;
#(
  parameter int unsigned NAREA    = 8,
  parameter int unsigned AREA_W   = $clog2(NAREA),
  parameter int unsigned CNT_W    = 3,
  parameter logic [7:0]  LW_MASK  = 8'b0100_0101,
  parameter int unsigned LW6_AREA = 6,
  parameter int unsigned MUX_BASE = 4
) (
  input  logic [1:0]        space,
  input  logic [AREA_W-1:0] area,
  input  logic [NAREA-1:0]  ctl_bits,
  input  logic [CODE_W-1:0] lw02_code,
  input  logic [CODE_W-1:0] lw6_code,
  output logic [CNT_W-1:0]  fix_len,
  output logic              samp_en
);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(1);
  localparam logic [CNT_W-1:0] LEN_LONG  = CNT_W'(2);
  localparam logic [CNT_W-1:0] LEN_MUX   = CNT_W'(MUX_BASE);

  logic              ctl;
  logic              has_lw;
  logic [CODE_W-1:0] code;

  always_comb begin
    ctl    = ctl_bits[area];
    has_lw = LW_MASK[area];
    code   = (area == AREA_W'(LW6_AREA)) ? lw6_code : lw02_code;
    unique case (space_e'(space))
      SP_MUX: begin
        fix_len = LEN_MUX;
        samp_en = 1'b1;
      end
      SP_DRAM: begin
        fix_len = ctl ? LEN_LONG : LEN_SHORT;
        samp_en = ctl;
      end
      default: begin
        if (has_lw) fix_len = LEN_LONG + CNT_W'(code);
        else        fix_len = ctl ? LEN_LONG : LEN_SHORT;
        samp_en = ctl;
      end
    endcase
  end
endmodule

// File: rtl/dma_ww_fsm.sv
module dma_ww_fsm #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] fix_len,
  input  logic             samp_en,
  input  logic             wait_n,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             se_q;
  logic             stretch;

  assign stretch = se_q && !wait_n;
  assign done    = busy && (cnt_q == '0) && !stretch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      se_q  <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        cnt_q <= fix_len - CNT_W'(1);
        se_q  <= samp_en;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (!stretch) begin
      busy <= 1'b0;
    end
  end

  // R9: done lasts one clock and closes the cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R9: a started cycle does not end before done
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  // R1: with sampling off the last fixed state always finishes
  p_no_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !se_q && cnt_q == '0) |-> done);
  // R10: a low WAIT sample in the last state keeps the cycle going
  p_wait_extends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q == '0 && se_q && !wait_n) |=> busy);
endmodule

// File: rtl/dma_wr_wait_ctl.sv
module dma_wr_wait_ctl
  import dma_ww_pkg::*;
#(
  parameter int unsigned NAREA    = 8,
  parameter int unsigned AREA_W   = $clog2(NAREA),
  parameter int unsigned MUX_BASE = 4,
  parameter int unsigned CNT_W    = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst_n,
  input  logic              start,
  input  logic [AREA_W-1:0] area,
  input  logic [1:0]        space,
  input  logic              wait_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              wait_pu_en,
  output logic              busy,
  output logic              done
);
  logic [NAREA-1:0]  ctl_bits;
  logic [CODE_W-1:0] lw02_code;
  logic [CODE_W-1:0] lw6_code;
  logic [CNT_W-1:0]  fix_len;
  logic              samp_en;
  logic              cyc_rst_n;

  assign cyc_rst_n = por_n & mrst_n;

  dma_ww_regs #(.NAREA(NAREA)) u_regs (
    .clk(clk), .por_n(por_n), .wr(reg_wr), .sel(reg_sel),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctl_bits(ctl_bits),
    .lw02_code(lw02_code), .lw6_code(lw6_code), .pu_en(wait_pu_en)
  );

  dma_ww_len #(.NAREA(NAREA), .AREA_W(AREA_W), .CNT_W(CNT_W), .MUX_BASE(MUX_BASE)) u_len (
    .space(space), .area(area), .ctl_bits(ctl_bits),
    .lw02_code(lw02_code), .lw6_code(lw6_code),
    .fix_len(fix_len), .samp_en(samp_en)
  );

  dma_ww_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(cyc_rst_n), .start(start), .fix_len(fix_len),
    .samp_en(samp_en), .wait_n(wait_n), .busy(busy), .done(done)
  );

  // R5: a multiplexed I/O cycle cannot finish in its first state
  p_mux_min_r5: assert property (@(posedge clk) disable iff (!cyc_rst_n)
    (!busy && start && space == 2'd2) |=> (busy && !done));
  // R8: manual reset clears the cycle without touching the pull-up bit
  p_mrst_regs_r8: assert property (@(posedge clk) disable iff (!por_n)
    (!mrst_n && !reg_wr) |=> $stable(wait_pu_en));
endmodule

// File: tb/dma_wr_wait_ctl_tb.sv
module dma_wr_wait_ctl_tb;
  typedef struct packed {
    logic [1:0] sp;
    logic [2:0] ar;
    logic       cb;
    logic [1:0] code;
    logic       wl;
    logic [2:0] nw;
    logic [3:0] len;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd1, 1'b0, 2'd0, 1'b1, 3'd0, 4'd1},  // R1
    '{2'd0, 3'd3, 1'b1, 2'd0, 1'b0, 3'd0, 4'd2},  // R2
    '{2'd0, 3'd5, 1'b1, 2'd0, 1'b0, 3'd2, 4'd4},  // R2 R10
    '{2'd3, 3'd7, 1'b0, 2'd0, 1'b1, 3'd0, 4'd1},  // R1
    '{2'd0, 3'd0, 1'b0, 2'd0, 1'b1, 3'd0, 4'd2},  // R3
    '{2'd0, 3'd2, 1'b1, 2'd3, 1'b0, 3'd1, 4'd6},  // R3
    '{2'd0, 3'd6, 1'b0, 2'd2, 1'b1, 3'd0, 4'd4},  // R3
    '{2'd0, 3'd6, 1'b1, 2'd1, 1'b0, 3'd3, 4'd6},  // R3 R10
    '{2'd1, 3'd4, 1'b0, 2'd3, 1'b1, 3'd0, 4'd1},  // R4
    '{2'd1, 3'd0, 1'b1, 2'd3, 1'b0, 3'd2, 4'd4},  // R4
    '{2'd2, 3'd1, 1'b0, 2'd0, 1'b0, 3'd1, 4'd5},  // R5
    '{2'd2, 3'd2, 1'b1, 2'd0, 1'b0, 3'd0, 4'd4}   // R5
  };

  logic        clk = 1'b0;
  logic        por_n = 1'b0, mrst_n = 1'b1, start = 1'b0, wait_n = 1'b1;
  logic [2:0]  area = '0;
  logic [1:0]  space = '0;
  logic        reg_wr = 1'b0, reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        wait_pu_en, busy, done;
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  dma_wr_wait_ctl u_dut (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .start(start), .area(area),
    .space(space), .wait_n(wait_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wait_pu_en(wait_pu_en),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic s, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic s, input string req, input int exp);
    @(negedge clk); reg_sel = s; #1;
    chk(req, reg_rdata, exp);
  endtask

  // run one cycle; wait low from state fixlen-1 for nw states, or all the time if wl
  task automatic run_cyc(input logic [1:0] sp, input logic [2:0] ar, input logic wl,
                         input int nw, input int exp_len, input string req);
    int n = 0;
    int done_cnt = 0;
    int done_at = -1;
    @(negedge clk); start = 1'b1; space = sp; area = ar; wait_n = 1'b1;
    @(negedge clk); start = 1'b0;
    while (busy && n < 20) begin
      if (wl) wait_n = 1'b0;
      else    wait_n = !(n >= exp_len - nw - 1 && n < exp_len - 1);
      #1;
      if (done) begin done_cnt++; done_at = n; end
      @(negedge clk); n++;
    end
    wait_n = 1'b1;
    chk({req, " length"}, n, exp_len);
    chk({req, " R9 done position"}, done_at, exp_len - 1);
    chk({req, " R9 done count"}, done_cnt, 1);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    // reset state: R6 R7
    @(negedge clk); #1;
    chk("R9 idle after reset", {busy, done}, 0);
    chk("R6 pull-up after reset", wait_pu_en, 1);
    rd_reg(1'b1, "R6 long-wait reset", 16'hF800);
    rd_reg(1'b0, "R7 control reset", 16'h00FF);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr_reg(1'b0, VEC[i].cb ? 16'h00FF : 16'h0000);
      wr_reg(1'b1, {1'b1, VEC[i].code, VEC[i].code, 11'h000});
      run_cyc(VEC[i].sp, VEC[i].ar, VEC[i].wl, int'(VEC[i].nw), int'(VEC[i].len),
              $sformatf("vec%0d", i));
    end

    // R6: reserved bits ignore writes, field placement
    wr_reg(1'b1, 16'h07FF);
    rd_reg(1'b1, "R6 reserved bits", 16'h0000);
    chk("R6 pull-up cleared", wait_pu_en, 0);
    wr_reg(1'b1, 16'hB000);
    rd_reg(1'b1, "R6 field readback", 16'hB000);
    // R7: control bits per area, upper byte zero
    wr_reg(1'b0, 16'hFF5A);
    rd_reg(1'b0, "R7 control readback", 16'h005A);
    // area 1 bit=1 -> 2 states, area 2 bit=0 code 01 -> 3 states ignoring WAIT
    run_cyc(2'd0, 3'd1, 1'b0, 0, 2, "R7 area1 bit set");
    run_cyc(2'd0, 3'd2, 1'b1, 0, 3, "R3 area2 code01 WAIT ignored");

    // R9: start while busy is ignored
    @(negedge clk); start = 1'b1; space = 2'd2; area = 3'd0; wait_n = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    #1; chk("R9 last state of first cycle", done, 1);
    @(negedge clk); #1;
    chk("R9 restart ignored", busy, 0);

    // R8: manual reset aborts cycle, keeps registers
    @(negedge clk); start = 1'b1; space = 2'd2;
    @(negedge clk); start = 1'b0;
    @(negedge clk); mrst_n = 1'b0; #1;
    chk("R8 busy cleared", busy, 0);
    @(negedge clk); mrst_n = 1'b1;
    rd_reg(1'b0, "R8 control kept", 16'h005A);
    rd_reg(1'b1, "R8 long-wait kept", 16'hB000);
    run_cyc(2'd2, 3'd3, 1'b0, 0, 4, "R8 cycle after manual reset");

    // R8: power-on reset restores registers
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd_reg(1'b1, "R8 por long-wait", 16'hF800);
    rd_reg(1'b0, "R8 por control", 16'h00FF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule